// File: doc/BRIEF.md
# Two-Wire Addressed Eight-Channel DAC Code Register

This block is the digital front end of an eight-channel, 8-bit DAC array. It is a write-only slave on a two-wire I2C bus. The system clock oversamples SCL and SDA, and the block detects START and STOP from them. It decodes the device address and acknowledges each byte it accepts by pulling SDA low. A complete write holds three bytes: an address byte, a sub-address byte that picks one channel, and one data byte that becomes that channel's code.

Three address bits come from strap pins, so up to eight of these blocks can share one bus and drive 64 channels in total. The outputs are the eight stored codes and a one-cycle load strobe per channel. The analog converter uses these to refresh its output.

Top module: `i2c_dac_regs`

## Requirements
- R1: An address byte whose seven upper bits equal 0011 followed by strap_sel[2:0] (MSB first), with bit 0 equal to 0, is acknowledged (SDA low during its ninth clock). Any other address byte gets no acknowledge, and the block ignores the bus until the next START.
- R2: An address byte that matches but has bit 0 equal to 1 (read) gets no acknowledge and causes no register change.
- R3: Bits 3..0 of the sub-address byte select the channel; bits 7..4 have no effect. Value n in 1..8 targets channel n, whose code appears on dac_codes[8n-1 : 8n-8].
- R4: A channel field of 0 or of 9..15 still lets the data byte be acknowledged, but no code changes and no strobe fires.
- R5: The data byte is taken MSB first and stored unchanged as the target channel's unsigned code.
- R6: load_strobe pulses for one clock, on at most one channel, in the clock where that channel's code is written. The codes do not change in any other clock.
- R7: A STOP or a repeated START before the eighth data bit aborts the write with no register change. A repeated START begins a new address decode.
- R8: After the one data byte, further bytes in the same transaction get no acknowledge and change nothing.
- R9: Reset (rst_n low) clears all codes to 0x00, clears the strobes and releases SDA.
- R10: sda_pull is asserted and released only while SCL is low. It is asserted after the eighth bit of an accepted byte and released at the SCL fall that ends the acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| strap_sel | input | 3 | Board straps forming address bits 3..1 |
| sda_pull | output | 1 | 1 pulls the open-drain SDA line low |
| dac_codes | output | 64 | Eight 8-bit channel codes, channel 1 in the low byte |
| load_strobe | output | 8 | One-clock write pulse per channel, bit 0 for channel 1 |

## Verification
The register load with its strobe and the start of the acknowledge pull-down are triggered by the same SCL fall. Both therefore land in one clock. The bench drives that fall and checks two things: the behavioural channel model matches on every clock once a short synchronizer window has passed, and the ninth-clock acknowledge is sampled on the line itself. A repeated START is also placed in the middle of a data byte, right where a bit capture would otherwise happen. The bench then confirms that the half-received byte leaves no trace and that the next transaction in the same frame writes normally.

// File: rtl/i2c_dac_regs.sv
module i2c_dac_regs #(
  parameter int          NCH        = 8,
  parameter logic [3:0]  DEV_PREFIX = 4'b0011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [2:0]        strap_sel,
  output logic              sda_pull,
  output logic [NCH*8-1:0]  dac_codes,
  output logic [NCH-1:0]    load_strobe
);
  localparam int BW   = 8;
  localparam int SELW = 4;
  localparam int CNTW = $clog2(BW + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_SUB, S_DATA, S_SKIP} st_t;

  logic [1:0]      scl_sy, sda_sy;
  logic            scl_q, sda_q;
  st_t             st;
  logic [CNTW-1:0] bcnt;
  logic [BW-1:0]   shreg;
  logic            in_ack;
  logic [SELW-1:0] chan;
  logic [NCH-1:0]  wr_sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end

  wire scl       = scl_sy[1];
  wire sda       = sda_sy[1];
  wire scl_rise  = scl & ~scl_q;
  wire scl_fall  = ~scl & scl_q;
  wire start_c   = scl & scl_q & sda_q & ~sda;
  wire stop_c    = scl & scl_q & ~sda_q & sda;
  wire byte_done = (bcnt == CNTW'(BW));
  wire addr_ok   = (shreg[7:1] == {DEV_PREFIX, strap_sel}) && !shreg[0];
  wire capture   = scl_rise && !in_ack && !byte_done &&
                   (st == S_ADDR || st == S_SUB || st == S_DATA);
  wire commit    = scl_fall && !in_ack && byte_done && (st == S_DATA);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; bcnt <= '0; shreg <= '0; in_ack <= 1'b0;
      chan <= '0; sda_pull <= 1'b0;
    end else if (start_c) begin
      st <= S_ADDR; bcnt <= '0; in_ack <= 1'b0; sda_pull <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE; bcnt <= '0; in_ack <= 1'b0; sda_pull <= 1'b0;
    end else if (capture) begin
      shreg <= {shreg[BW-2:0], sda};
      bcnt  <= bcnt + 1'b1;
    end else if (scl_fall) begin
      if (in_ack) begin
        in_ack <= 1'b0; sda_pull <= 1'b0; bcnt <= '0;
      end else if (byte_done) begin
        in_ack <= 1'b1;
        case (st)
          S_ADDR: if (addr_ok) begin sda_pull <= 1'b1; st <= S_SUB; end
                  else st <= S_SKIP;
          S_SUB:  begin sda_pull <= 1'b1; chan <= shreg[SELW-1:0]; st <= S_DATA; end
          S_DATA: begin sda_pull <= 1'b1; st <= S_SKIP; end
          default: st <= S_SKIP;
        endcase
      end
    end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [BW-1:0] code_q;
    assign wr_sel[i] = commit && (chan == SELW'(i + 1));
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)         code_q <= '0;
      else if (wr_sel[i]) code_q <= shreg;
    assign dac_codes[i*BW +: BW] = code_q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) load_strobe <= '0;
    else        load_strobe <= wr_sel;

  // R10
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_pull) || $fell(sda_pull)) |-> !scl);

  // R6
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_strobe));

  // R6
  codes_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_strobe == '0) |-> $stable(dac_codes));

  // R4
  strobe_chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|load_strobe) |-> (chan != '0 && chan <= SELW'(NCH)));

  // R7
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_c || start_c) |=> (!sda_pull && load_strobe == '0));

  // R8
  skip_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP && !in_ack) |-> !sda_pull);
endmodule

// File: tb/i2c_dac_regs_tb.sv
`timescale 1ns/1ps
module i2c_dac_regs_tb;
  localparam int NCH = 8;
  localparam int CW  = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic sda_pull;
  logic [NCH*CW-1:0] dac_codes;
  logic [NCH-1:0] load_strobe;
  wire sda_line = sda_m & ~sda_pull;

  i2c_dac_regs u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .strap_sel(strap), .sda_pull(sda_pull), .dac_codes(dac_codes),
    .load_strobe(load_strobe));

  int tests = 0, fails = 0, mon_err = 0, grace = 0;
  bit done = 1'b0;
  logic [CW-1:0] exp_code [NCH];
  int exp_strb [NCH];
  int obs_strb [NCH];
  logic prev_pull = 1'b0;

  initial for (int i = 0; i < NCH; i++) begin exp_code[i] = '0; exp_strb[i] = 0; obs_strb[i] = 0; end

  always @(negedge clk) begin
    for (int i = 0; i < NCH; i++) obs_strb[i] += int'(load_strobe[i]);
    if (rst_n && sda_pull !== prev_pull && scl_m) begin
      mon_err++;
      $display("mismatch: sda_pull toggled while SCL high at %0t", $time);
    end
    prev_pull = sda_pull;
    if (rst_n) begin
      if (grace > 0) grace--;
      else for (int i = 0; i < NCH; i++)
        if (dac_codes[i*CW +: CW] !== exp_code[i]) begin
          mon_err++;
          if (mon_err < 6) $display("mismatch: ch%0d code %0h model %0h at %0t",
                                    i + 1, dac_codes[i*CW +: CW], exp_code[i], $time);
        end
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic chk_model(string req);
    check(mon_err == 0, req, "per-clock model compare errors", mon_err, 0);
    mon_err = 0;
  endtask

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic send_bit(bit b);
    scl_m = 1'b0; tick(4); sda_m = b; tick(4); scl_m = 1'b1; tick(8);
  endtask

  task automatic bus_start;
    scl_m = 1'b0; tick(4); sda_m = 1'b1; tick(4); scl_m = 1'b1; tick(8);
    sda_m = 1'b0; tick(8); scl_m = 1'b0; tick(4);
  endtask

  task automatic bus_stop;
    scl_m = 1'b0; tick(4); sda_m = 1'b0; tick(4); scl_m = 1'b1; tick(8);
    sda_m = 1'b1; tick(8);
  endtask

  task automatic send_byte(logic [7:0] b, int commit_ch, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    scl_m = 1'b0;
    if (commit_ch > 0) begin
      exp_code[commit_ch-1] = b; exp_strb[commit_ch-1]++; grace = 6;
    end
    tick(4); sda_m = 1'b1; tick(4);
    acked = !sda_line;
    scl_m = 1'b1; tick(8);
  endtask

  task automatic write_txn(logic [6:0] a, bit rd, logic [7:0] sub, logic [7:0] d,
                           output bit ka, output bit ks, output bit kd);
    bit match;
    int ch;
    match = (a == {4'b0011, strap}) && !rd;
    ch = (match && sub[3:0] >= 1 && sub[3:0] <= NCH) ? int'(sub[3:0]) : 0;
    bus_start;
    send_byte({a, rd}, 0, ka);
    send_byte(sub, 0, ks);
    send_byte(d, ch, kd);
    bus_stop;
  endtask

  initial begin
    bit ka, ks, kd, kx;
    int bad;
    tick(5); rst_n = 1'b1; tick(4);

    check(dac_codes == '0, "R9", "codes after reset", dac_codes, 0);
    check(sda_pull == 1'b0, "R9", "sda_pull after reset", sda_pull, 0);

    write_txn(7'b0011101, 1'b0, 8'h01, 8'hA5, ka, ks, kd);
    check(ka && ks && kd, "R1", "acks for matching write", {ka, ks, kd}, 3'b111);
    check(dac_codes[7:0] == 8'hA5, "R5", "ch1 code", dac_codes[7:0], 8'hA5);
    chk_model("R5");

    write_txn(7'b0011101, 1'b0, 8'hF8, 8'h3C, ka, ks, kd);
    check(dac_codes[63:56] == 8'h3C, "R3", "ch8 via sub F8", dac_codes[63:56], 8'h3C);
    chk_model("R3");

    write_txn(7'b0011101, 1'b0, 8'h00, 8'h77, ka, ks, kd);
    check(kd, "R4", "data ack for channel 0", kd, 1);
    write_txn(7'b0011101, 1'b0, 8'h09, 8'h11, ka, ks, kd);
    check(kd, "R4", "data ack for channel 9", kd, 1);
    write_txn(7'b0011101, 1'b0, 8'h0F, 8'h22, ka, ks, kd);
    check(kd, "R4", "data ack for channel 15", kd, 1);
    chk_model("R4");

    write_txn(7'b0011100, 1'b0, 8'h02, 8'h55, ka, ks, kd);
    check(!ka && !ks && !kd, "R1", "acks for strap mismatch", {ka, ks, kd}, 0);
    write_txn(7'b1011101, 1'b0, 8'h02, 8'h55, ka, ks, kd);
    check(!ka, "R1", "ack for prefix mismatch", ka, 0);
    chk_model("R1");

    write_txn(7'b0011101, 1'b1, 8'h02, 8'h55, ka, ks, kd);
    check(!ka && !ks && !kd, "R2", "acks for read request", {ka, ks, kd}, 0);
    chk_model("R2");

    bus_start;
    send_byte(8'b0011_1010, 0, ka);
    send_byte(8'h03, 0, ks);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop;
    check(dac_codes[23:16] == 8'h00, "R7", "ch3 after STOP abort", dac_codes[23:16], 0);

    bus_start;
    send_byte(8'b0011_1010, 0, ka);
    send_byte(8'h04, 0, ks);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    bus_start;
    send_byte(8'b0011_1010, 0, ka);
    send_byte(8'h05, 0, ks);
    send_byte(8'h5A, 5, kd);
    bus_stop;
    check(dac_codes[31:24] == 8'h00, "R7", "ch4 after restart abort", dac_codes[31:24], 0);
    check(ka && kd && dac_codes[39:32] == 8'h5A, "R7", "ch5 after restart",
          dac_codes[39:32], 8'h5A);
    chk_model("R7");

    bus_start;
    send_byte(8'b0011_1010, 0, ka);
    send_byte(8'h02, 0, ks);
    send_byte(8'h66, 2, kd);
    send_byte(8'h01, 0, kx);
    bus_stop;
    check(!kx, "R8", "ack of extra byte", kx, 0);
    check(dac_codes[15:8] == 8'h66 && dac_codes[7:0] == 8'hA5, "R8", "ch2/ch1 after extra byte",
          dac_codes[15:0], 16'h66A5);
    chk_model("R8");

    strap = 3'b010; tick(4);
    write_txn(7'b0011010, 1'b0, 8'h06, 8'hC3, ka, ks, kd);
    check(ka && dac_codes[47:40] == 8'hC3, "R1", "new strap write", dac_codes[47:40], 8'hC3);
    write_txn(7'b0011101, 1'b0, 8'h06, 8'h00, ka, ks, kd);
    check(!ka, "R1", "old strap address", ka, 0);
    chk_model("R1");

    bad = 0;
    for (int i = 0; i < NCH; i++) if (obs_strb[i] != exp_strb[i]) bad++;
    check(bad == 0, "R6", "channels with wrong strobe count", bad, 0);
    chk_model("R10");

    rst_n = 1'b0;
    for (int i = 0; i < NCH; i++) exp_code[i] = '0;
    tick(3);
    check(dac_codes == '0 && sda_pull == 1'b0, "R9", "codes after mid-run reset", dac_codes, 0);
    rst_n = 1'b1; tick(4);
    write_txn(7'b0011010, 1'b0, 8'h07, 8'h81, ka, ks, kd);
    check(dac_codes[55:48] == 8'h81, "R9", "write after reset", dac_codes[55:48], 8'h81);
    chk_model("R9");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule